// File: doc/BRIEF.md
# Rectangular Blit Address Generator

This block copies a rectangular image from a linear source buffer into a region of a framebuffer. It produces one 16-bit word transfer at a time. The source is read at consecutive word addresses. The destination walks each image row inside the framebuffer and then jumps over the rest of that screen row to reach the start of the next image row. Both the within-row step and the row-end jump are applied to one destination pointer, so the block needs no second counter for screen rows.

Each word is read from the source port and held in a one-word register. It is then written to the destination port. One word takes three cycles: read, capture, write. A start pulse in the idle state latches the geometry. When the last word has been written, the block raises done and clears busy. It holds done until an acknowledge pulse arrives.

The controller is a five-state machine:
- `S_IDLE`: waiting for a start pulse.
- `S_READ`: source read request.
- `S_LATCH`: read data captured.
- `S_WRITE`: destination write, and both pointers advance.
- `S_DONE`: finished, waiting for acknowledge.

Transitions:
- idle→read: start with a non-empty image.
- idle→done: start with an empty image.
- read→latch and latch→write: always taken.
- write→read: words remain.
- write→done: the last element of the last row has been written.
- done→idle: `done_ack` is high.

Top module: `blit_agen`

## Requirements
- R1: After reset, `rd_en`, `wr_en`, `busy` and `done` are all 0.
- R2: A blit performs exactly `(img_w*px_bytes/2)` words per row times `img_h` rows. Each word is one 16-bit read followed by one 16-bit write.
- R3: The first read address is `src_base`. Each later read address is the previous one plus 2, including across row ends.
- R4: The first write address is `fb_base + (pos_x with bit 0 cleared)*px_bytes + pos_y*scr_width*px_bytes`. An odd `pos_x` therefore gives the same start as `pos_x-1`.
- R5: After a non-final element of a row, the write address advances by 2. After the last element of a row, it advances by `(scr_width-img_w)*px_bytes + 2`.
- R6: Counting the cycle after the start edge as cycle 0, word k is read in cycle 3k and written in cycle 3k+2. The written data equals the data returned for that read. Read and write requests are never active in the same cycle.
- R7: In the cycle after the last write, `done` is 1 and `busy` is 0. `done` stays 1 until `done_ack` is sampled high, and is 0 in the following cycle.
- R8: If `img_w`, `img_h` or the elements-per-row count is zero, `done` is 1 in the cycle after start. No read or write occurs.
- R9: A start pulse while busy or while done is ignored. It does not change the running address sequence and does not begin a new transfer.
- R10: Read data is returned by memory one cycle after `rd_en` and is captured into the holding register before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted only in idle |
| done_ack | input | 1 | Acknowledge; clears done |
| src_base | input | AW | Source byte address of the first word |
| fb_base | input | AW | Framebuffer byte base address |
| scr_width | input | DIM_W | Screen width in pixels |
| px_bytes | input | BPP_W | Bytes per pixel |
| img_w | input | DIM_W | Image width in pixels |
| img_h | input | DIM_W | Image height in rows |
| pos_x | input | DIM_W | Target column |
| pos_y | input | DIM_W | Target row |
| rd_en | output | 1 | Source read request |
| rd_addr | output | AW | Source read byte address |
| rd_data | input | 16 | Read data, valid one cycle after `rd_en` |
| wr_en | output | 1 | Destination write request |
| wr_addr | output | AW | Destination write byte address |
| wr_data | output | 16 | Destination write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished, awaiting acknowledge |

## Verification
The hardest situations to reach are a start pulse that arrives in the middle of a transfer and a start pulse that arrives while done is still pending. Both must leave the address sequence unchanged.

The bench reaches the first by raising start with different geometry a few cycles into a multi-row blit. It then keeps comparing every cycle against the sequence it predicted before that pulse. It reaches the second by pulsing start during the done wait and checking that no request appears. Row-end jumps are checked with images narrower than the screen, an odd target column and multi-byte pixels.

// File: rtl/blit_pkg.sv
package blit_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_READ  = 3'd1,
        S_LATCH = 3'd2,
        S_WRITE = 3'd3,
        S_DONE  = 3'd4
    } blit_state_t;

    localparam int WORD_W     = 16;
    localparam int WORD_BYTES = 2;
endpackage

// File: rtl/blit_setup.sv
module blit_setup #(
    parameter int AW    = 32,
    parameter int DIM_W = 12,
    parameter int BPP_W = 3,
    localparam int CW   = DIM_W + BPP_W
) (
    input  logic [AW-1:0]    fb_base,
    input  logic [DIM_W-1:0] scr_width,
    input  logic [BPP_W-1:0] px_bytes,
    input  logic [DIM_W-1:0] img_w,
    input  logic [DIM_W-1:0] img_h,
    input  logic [DIM_W-1:0] pos_x,
    input  logic [DIM_W-1:0] pos_y,
    output logic [AW-1:0]    dst_start,
    output logic [AW-1:0]    row_mod,
    output logic [CW-1:0]    elems,
    output logic             empty
);
    logic [AW-1:0] x_even, bpp_w, stride_b, width_b;
    logic [CW:0]   row_bytes;

    always_comb begin
        x_even    = AW'({pos_x[DIM_W-1:1], 1'b0});
        bpp_w     = AW'(px_bytes);
        stride_b  = AW'(scr_width) * bpp_w;
        width_b   = AW'(img_w) * bpp_w;
        row_bytes = (CW+1)'(img_w) * (CW+1)'(px_bytes);
        elems     = row_bytes[CW:1];
        dst_start = fb_base + x_even * bpp_w + AW'(pos_y) * stride_b;
        row_mod   = stride_b - width_b + AW'(blit_pkg::WORD_BYTES);
        empty     = (elems == '0) || (img_h == '0);
    end
endmodule

// File: rtl/blit_walker.sv
module blit_walker #(
    parameter int AW    = 32,
    parameter int DIM_W = 12,
    parameter int BPP_W = 3,
    localparam int CW   = DIM_W + BPP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [AW-1:0]    src_base,
    input  logic [AW-1:0]    dst_start,
    input  logic [AW-1:0]    row_mod,
    input  logic [CW-1:0]    elems,
    input  logic [DIM_W-1:0] rows,
    output logic [AW-1:0]    src_ptr,
    output logic [AW-1:0]    dst_ptr,
    output logic             last_col,
    output logic             last_row
);
    localparam logic [AW-1:0] STEP = AW'(blit_pkg::WORD_BYTES);

    logic [CW-1:0]    col, elems_q;
    logic [DIM_W-1:0] row, rows_q;
    logic [AW-1:0]    mod_q;

    assign last_col = (col == elems_q - CW'(1));
    assign last_row = (row == rows_q - DIM_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_ptr <= '0;
            dst_ptr <= '0;
            col     <= '0;
            row     <= '0;
            elems_q <= '0;
            rows_q  <= '0;
            mod_q   <= '0;
        end else if (load) begin
            src_ptr <= src_base;
            dst_ptr <= dst_start;
            col     <= '0;
            row     <= '0;
            elems_q <= elems;
            rows_q  <= rows;
            mod_q   <= row_mod;
        end else if (step) begin
            src_ptr <= src_ptr + STEP;
            if (last_col) begin
                dst_ptr <= dst_ptr + mod_q;
                col     <= '0;
                row     <= row + DIM_W'(1);
            end else begin
                dst_ptr <= dst_ptr + STEP;
                col     <= col + CW'(1);
            end
        end
    end

    assert_src_contiguous_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (src_ptr == $past(src_ptr) + STEP));

    assert_dst_in_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !last_col) |=> (dst_ptr == $past(dst_ptr) + STEP));

    assert_dst_row_jump_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && last_col) |=> (dst_ptr == $past(dst_ptr) + mod_q));
endmodule

// File: rtl/blit_agen.sv
module blit_agen #(
    parameter int AW    = 32,
    parameter int DIM_W = 12,
    parameter int BPP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             done_ack,
    input  logic [AW-1:0]    src_base,
    input  logic [AW-1:0]    fb_base,
    input  logic [DIM_W-1:0] scr_width,
    input  logic [BPP_W-1:0] px_bytes,
    input  logic [DIM_W-1:0] img_w,
    input  logic [DIM_W-1:0] img_h,
    input  logic [DIM_W-1:0] pos_x,
    input  logic [DIM_W-1:0] pos_y,
    output logic             rd_en,
    output logic [AW-1:0]    rd_addr,
    input  logic [15:0]      rd_data,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [15:0]      wr_data,
    output logic             busy,
    output logic             done
);
    import blit_pkg::*;
    localparam int CW = DIM_W + BPP_W;

    blit_state_t        state, state_nx;
    logic [AW-1:0]      dst_start, row_mod;
    logic [CW-1:0]      elems;
    logic               empty, last_col, last_row, load, step;
    logic [WORD_W-1:0]  hold;

    blit_setup #(.AW(AW), .DIM_W(DIM_W), .BPP_W(BPP_W)) u_setup (
        .fb_base(fb_base), .scr_width(scr_width), .px_bytes(px_bytes),
        .img_w(img_w), .img_h(img_h), .pos_x(pos_x), .pos_y(pos_y),
        .dst_start(dst_start), .row_mod(row_mod), .elems(elems), .empty(empty)
    );

    assign load = (state == S_IDLE) && start;
    assign step = (state == S_WRITE);

    blit_walker #(.AW(AW), .DIM_W(DIM_W), .BPP_W(BPP_W)) u_walker (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .src_base(src_base), .dst_start(dst_start), .row_mod(row_mod),
        .elems(elems), .rows(img_h),
        .src_ptr(rd_addr), .dst_ptr(wr_addr),
        .last_col(last_col), .last_row(last_row)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (start) state_nx = empty ? S_DONE : S_READ;
            S_READ:  state_nx = S_LATCH;
            S_LATCH: state_nx = S_WRITE;
            S_WRITE: state_nx = (last_col && last_row) ? S_DONE : S_READ;
            S_DONE:  if (done_ack) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 hold <= '0;
        else if (state == S_LATCH)  hold <= rd_data;
    end

    always_comb begin
        rd_en   = (state == S_READ);
        wr_en   = (state == S_WRITE);
        busy    = (state == S_READ) || (state == S_LATCH) || (state == S_WRITE);
        done    = (state == S_DONE);
        wr_data = hold;
    end

    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));

    assert_write_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(rd_en, 2));

    assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !rd_en && !wr_en));

    assert_done_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_ack) |=> done);

    assert_empty_finish_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && empty) |=> (done && !rd_en));

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !(wr_en && last_col && last_row)) |=> busy);
endmodule

// File: tb/blit_agen_tb.sv
module blit_agen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32, DIM_W = 12, BPP_W = 3;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, done_ack = 1'b0;
    logic [AW-1:0] src_base = '0, fb_base = '0;
    logic [DIM_W-1:0] scr_width = '0, img_w = '0, img_h = '0, pos_x = '0, pos_y = '0;
    logic [BPP_W-1:0] px_bytes = '0;
    logic rd_en, wr_en, busy, done;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [15:0] rd_data, wr_data;

    int checks = 0, fails = 0, cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blit_agen #(.AW(AW), .DIM_W(DIM_W), .BPP_W(BPP_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .done_ack(done_ack),
        .src_base(src_base), .fb_base(fb_base), .scr_width(scr_width),
        .px_bytes(px_bytes), .img_w(img_w), .img_h(img_h), .pos_x(pos_x),
        .pos_y(pos_y), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .done(done)
    );

    function automatic logic [15:0] mem_word(input logic [AW-1:0] a);
        return a[15:0] ^ 16'h5A3C;
    endfunction

    // R10: memory answers one cycle after the request
    always_ff @(posedge clk) if (rd_en) rd_data <= mem_word(rd_addr);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            fails = fails + 1; checks = checks + 1;
            $display("FAIL watchdog: run did not end, actual %0d cycles expected < 20000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Reference: predicted address lists built from the requirements
    task automatic run_case(input int sb, input int fb, input int sw, input int bpp,
                            input int w, input int h, input int x, input int y,
                            input bit poke_busy);
        logic [AW-1:0] exp_src[$], exp_dst[$];
        int epr, n;
        logic [AW-1:0] d, s;
        src_base = AW'(sb); fb_base = AW'(fb); scr_width = DIM_W'(sw);
        px_bytes = BPP_W'(bpp); img_w = DIM_W'(w); img_h = DIM_W'(h);
        pos_x = DIM_W'(x); pos_y = DIM_W'(y);
        epr = (w * bpp) / 2;
        n = (epr == 0 || h == 0) ? 0 : epr * h;
        s = AW'(sb);
        d = AW'(fb + (x & ~1) * bpp + y * sw * bpp);       // R4
        for (int r = 0; r < h && n > 0; r++)
            for (int c = 0; c < epr; c++) begin
                exp_src.push_back(s); exp_dst.push_back(d);
                s = s + 2;                                      // R3
                d = (c == epr - 1) ? d + AW'((sw - w) * bpp + 2) : d + 2;  // R5
            end
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int c = 0; c <= 3 * n; c++) begin
            bit exp_rd, exp_wr;
            exp_rd = (c < 3 * n) && (c % 3 == 0);
            exp_wr = (c < 3 * n) && (c % 3 == 2);
            check("R6", "rd_en", 64'(rd_en), 64'(exp_rd));
            check("R6", "wr_en", 64'(wr_en), 64'(exp_wr));
            check("R7", "busy", 64'(busy), 64'(c < 3 * n));
            check(n == 0 ? "R8" : "R7", "done", 64'(done), 64'(c == 3 * n));
            if (exp_rd) check("R3", "rd_addr", 64'(rd_addr), 64'(exp_src[c/3]));
            if (exp_wr) begin
                check(c == 2 ? "R4" : "R5", "wr_addr", 64'(wr_addr), 64'(exp_dst[c/3]));
                check("R10", "wr_data", 64'(wr_data), 64'(mem_word(exp_src[c/3])));
            end
            if (poke_busy && c == 4) begin   // R9: start while busy, new geometry
                img_w = 12'd1; img_h = 12'd1; src_base = 32'h0; start = 1'b1;
            end else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        // R2: no extra words after the predicted count
        check("R2", "rd_en after end", 64'(rd_en), 64'd0);
        // R9: start while done is ignored
        start = 1'b1; @(negedge clk); start = 1'b0;
        check("R9", "rd_en on start during done", 64'(rd_en), 64'd0);
        check("R7", "done held", 64'(done), 64'd1);
        done_ack = 1'b1; @(negedge clk); done_ack = 1'b0;
        check("R7", "done after ack", 64'(done), 64'd0);
        check("R7", "busy after ack", 64'(busy), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "rd_en", 64'(rd_en), 64'd0);
        check("R1", "wr_en", 64'(wr_en), 64'd0);
        check("R1", "busy", 64'(busy), 64'd0);
        check("R1", "done", 64'(done), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        run_case(32'h1000, 32'h8000, 10, 2, 4, 3, 3, 2, 1'b1);   // odd x, R4
        run_case(32'h2000, 32'h9000, 8, 2, 3, 2, 0, 1, 1'b0);
        run_case(32'h3000, 32'hA000, 20, 4, 2, 3, 6, 0, 1'b0);
        run_case(32'h3100, 32'hB000, 16, 1, 6, 2, 4, 3, 1'b0);
        run_case(32'h4000, 32'hC000, 10, 2, 5, 1, 2, 2, 1'b0);   // single row
        run_case(32'h5000, 32'hD000, 10, 2, 0, 4, 0, 0, 1'b0);   // R8 zero width
        run_case(32'h6000, 32'hE000, 10, 2, 4, 0, 0, 0, 1'b0);   // R8 zero height
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule